// File: doc/BRIEF.md
# Isochronous Cycle Event Monitor

The monitor keeps a local serial-bus cycle timer and turns its progress, and the cycle starts seen on the bus, into one-clock event pulses for an interrupt register. The timer has three fields: a sub-cycle offset, a cycle count and a seconds field. The offset advances on each tick enable. When it wraps, a new isochronous cycle begins. Five events come out: new cycle, 64-second tick, cycle lost, cycle inconsistent and cycle too long.

A received cycle start arrives as a strobe that carries its seconds and cycle-count values. The monitor compares these with the local timer. A locally transmitted cycle start arrives as a plain strobe. Either kind of strobe counts as the cycle start of the current cycle. A per-cycle state machine tracks whether a start has been seen and how long isochronous activity has run since then. It can therefore report a cycle with no start. In cycle-master mode it can also report a cycle whose activity overruns a parameterised limit. Packet parsing, arbitration and the interrupt register itself sit outside the block.

The per-cycle state machine has four states:

- `ST_FIRST`: reset until the first new-cycle point.
- `ST_AWAIT`: a new cycle has begun and no start has been seen yet.
- `ST_ACTIVE`: a start has been seen and activity is being timed.
- `ST_QUIET`: activity has finished, or an overrun has been reported.

It has these transitions:

- FIRST→AWAIT on a wrap without a start.
- FIRST→ACTIVE on a wrap together with a start.
- AWAIT→ACTIVE on a start.
- AWAIT→AWAIT on a wrap without a start, which reports a lost cycle.
- ACTIVE→QUIET on the done input or on an overrun.
- ACTIVE/QUIET→AWAIT on a wrap without a start.
- ACTIVE/QUIET→ACTIVE on a wrap together with a start.

Top module: `iso_cycle_monitor`

## Requirements
- R1: The offset counts 0 to OFF_LEN-1, advancing only on clocks with `tick_en_i` high. `new_cycle_o` is high for the one clock after the clock whose tick takes the offset from OFF_LEN-1 to 0.
- R2: The cycle count advances on each offset wrap and wraps from CYC_PER_SEC-1 to 0, which increments the 7-bit seconds field modulo 128. `sec64_o` pulses together with `new_cycle_o` exactly when that increment toggles seconds bit 6, that is when the low six seconds bits were all ones.
- R3: `cycle_incons_o` is high for the one clock after a clock with `rx_start_i` high whose `rx_sec_i` or `rx_cnt_i` differs from the local seconds or cycle count held at that clock.
- R4: A received start whose seconds and count both match the local timer raises no inconsistent flag and leaves the timer's later progress unchanged.
- R5: `cycle_lost_o` pulses together with `new_cycle_o` when no start (`rx_start_i` or `tx_start_i`) occurred since the previous new-cycle point. The first new-cycle point after reset never reports a loss.
- R6: A start on the same clock as an offset wrap belongs to the new cycle. It does not prevent a loss report for the cycle that is ending.
- R7: When `master_i` is high, `cycle_long_o` is high for the one clock after the LONG_LIMIT-th tick following a start, unless `iso_done_i` came first or arrived on that clock. It fires at most once per cycle. A wrap on that clock takes precedence.
- R8: No cycle-too-long flag is raised on a clock where `master_i` is low. Time keeps counting, saturating at the limit, so that if master mode is raised later the flag fires on the next tick.
- R9: While `rst_n` is low all outputs are low, and the timer and state machine return to zero and `ST_FIRST`.
- R10: Every event output is registered and one clock wide (OFF_LEN of at least 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en_i | input | 1 | Advances the offset by one |
| rx_start_i | input | 1 | Received cycle-start strobe |
| rx_sec_i | input | SEC_W | Seconds value in the received start |
| rx_cnt_i | input | CNT_W | Cycle count in the received start |
| tx_start_i | input | 1 | Locally transmitted cycle-start strobe |
| master_i | input | 1 | Cycle-master mode |
| iso_done_i | input | 1 | Isochronous activity of this cycle finished |
| new_cycle_o | output | 1 | New cycle began |
| sec64_o | output | 1 | 64-second tick |
| cycle_lost_o | output | 1 | Cycle ended without a start |
| cycle_incons_o | output | 1 | Received start disagrees with the timer |
| cycle_long_o | output | 1 | Activity overran LONG_LIMIT ticks |

## Verification
The bench runs four input patterns, each of which separates a different behaviour:

- **Ticks every clock, no starts:** every new-cycle point is a loss except the first after reset. This separates the missed-cycle path from the reset guard.
- **Master mode with sparse starts and done strobes:** this separates an overrun from activity that finished in time, and exercises starts that land on a wrap.
- **Long steady run with mostly matching received starts:** the seconds field carries across bit 6, and this run separates matching starts from starts with a single altered field.
- **Fully random phase:** gaps in the tick enable and toggling master mode try the saturating timer and the master-only gating.

// File: rtl/iso_mon_pkg.sv
`timescale 1ns/1ps
package iso_mon_pkg;
    typedef enum logic [1:0] {
        ST_FIRST  = 2'd0,
        ST_AWAIT  = 2'd1,
        ST_ACTIVE = 2'd2,
        ST_QUIET  = 2'd3
    } cyc_state_t;
endpackage

// File: rtl/iso_cycle_timer.sv
`timescale 1ns/1ps
module iso_cycle_timer #(
    parameter int OFF_LEN     = 3072,
    parameter int CYC_PER_SEC = 8000,
    parameter int OFF_W       = 12,
    parameter int CNT_W       = 13,
    parameter int SEC_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en_i,
    output logic [SEC_W-1:0] sec_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             sec_roll_o
);
    localparam logic [OFF_W-1:0] OFF_LAST = OFF_W'(OFF_LEN - 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_SEC - 1);
    localparam int               LOW_W    = SEC_W - 1;

    logic [OFF_W-1:0] off_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SEC_W-1:0] sec_q;

    // offset wrap marks the start of a new isochronous cycle
    always_comb begin
        wrap_o     = tick_en_i && (off_q == OFF_LAST);
        sec_roll_o = wrap_o && (cnt_q == CNT_LAST) && (&sec_q[LOW_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q <= '0;
            cnt_q <= '0;
            sec_q <= '0;
        end else if (tick_en_i) begin
            if (off_q == OFF_LAST) begin
                off_q <= '0;
                if (cnt_q == CNT_LAST) begin
                    cnt_q <= '0;
                    sec_q <= sec_q + 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end else begin
                off_q <= off_q + 1'b1;
            end
        end
    end

    assign sec_o = sec_q;
    assign cnt_o = cnt_q;
endmodule

// File: rtl/iso_cycle_fsm.sv
`timescale 1ns/1ps
module iso_cycle_fsm
    import iso_mon_pkg::*;
#(
    parameter int LONG_LIMIT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en_i,
    input  logic wrap_i,
    input  logic start_i,
    input  logic master_i,
    input  logic iso_done_i,
    output logic lost_o,
    output logic long_o
);
    localparam int            EL_W    = $clog2(LONG_LIMIT + 1);
    localparam logic [EL_W-1:0] EL_LAST = EL_W'(LONG_LIMIT - 1);

    cyc_state_t      st_q, st_d;
    logic [EL_W-1:0] el_q, el_d;
    logic            lost_d, long_d;

    always_comb begin
        st_d   = st_q;
        el_d   = el_q;
        lost_d = 1'b0;
        long_d = 1'b0;
        unique case (st_q)
            ST_FIRST: begin
                if (wrap_i) begin
                    st_d = start_i ? ST_ACTIVE : ST_AWAIT;
                    el_d = '0;
                end
            end
            ST_AWAIT: begin
                if (wrap_i) begin
                    lost_d = 1'b1;
                    st_d   = start_i ? ST_ACTIVE : ST_AWAIT;
                    el_d   = '0;
                end else if (start_i) begin
                    st_d = ST_ACTIVE;
                    el_d = '0;
                end
            end
            ST_ACTIVE: begin
                if (wrap_i) begin
                    st_d = start_i ? ST_ACTIVE : ST_AWAIT;
                    el_d = '0;
                end else if (iso_done_i) begin
                    st_d = ST_QUIET;
                end else if (tick_en_i) begin
                    if (el_q == EL_LAST) begin
                        if (master_i) begin
                            long_d = 1'b1;
                            st_d   = ST_QUIET;
                        end
                    end else begin
                        el_d = el_q + 1'b1;
                    end
                end
            end
            ST_QUIET: begin
                if (wrap_i) begin
                    st_d = start_i ? ST_ACTIVE : ST_AWAIT;
                    el_d = '0;
                end
            end
            default: st_d = ST_FIRST;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_FIRST;
            el_q <= '0;
        end else begin
            st_q <= st_d;
            el_q <= el_d;
        end
    end

    // registered event outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost_o <= 1'b0;
            long_o <= 1'b0;
        end else begin
            lost_o <= lost_d;
            long_o <= long_d;
        end
    end
endmodule

// File: rtl/iso_cycle_monitor.sv
`timescale 1ns/1ps
module iso_cycle_monitor #(
    parameter int OFF_LEN     = 3072,
    parameter int CYC_PER_SEC = 8000,
    parameter int LONG_LIMIT  = 2048,
    parameter int OFF_W       = 12,
    parameter int CNT_W       = 13,
    parameter int SEC_W       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en_i,
    input  logic             rx_start_i,
    input  logic [SEC_W-1:0] rx_sec_i,
    input  logic [CNT_W-1:0] rx_cnt_i,
    input  logic             tx_start_i,
    input  logic             master_i,
    input  logic             iso_done_i,
    output logic             new_cycle_o,
    output logic             sec64_o,
    output logic             cycle_lost_o,
    output logic             cycle_incons_o,
    output logic             cycle_long_o
);
    logic [SEC_W-1:0] sec_w;
    logic [CNT_W-1:0] cnt_w;
    logic             wrap_w, roll_w, start_w, mismatch_w;

    iso_cycle_timer #(
        .OFF_LEN(OFF_LEN), .CYC_PER_SEC(CYC_PER_SEC),
        .OFF_W(OFF_W), .CNT_W(CNT_W), .SEC_W(SEC_W)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
        .sec_o(sec_w), .cnt_o(cnt_w),
        .wrap_o(wrap_w), .sec_roll_o(roll_w)
    );

    assign start_w    = rx_start_i | tx_start_i;
    assign mismatch_w = rx_start_i && ((rx_sec_i != sec_w) || (rx_cnt_i != cnt_w));

    iso_cycle_fsm #(
        .LONG_LIMIT(LONG_LIMIT)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
        .wrap_i(wrap_w), .start_i(start_w), .master_i(master_i),
        .iso_done_i(iso_done_i),
        .lost_o(cycle_lost_o), .long_o(cycle_long_o)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            new_cycle_o    <= 1'b0;
            sec64_o        <= 1'b0;
            cycle_incons_o <= 1'b0;
        end else begin
            new_cycle_o    <= wrap_w;
            sec64_o        <= roll_w;
            cycle_incons_o <= mismatch_w;
        end
    end
endmodule

// File: rtl/iso_cycle_monitor_chk.sv
`timescale 1ns/1ps
module iso_cycle_monitor_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_start_i,
    input logic master_i,
    input logic new_cycle_o,
    input logic sec64_o,
    input logic cycle_lost_o,
    input logic cycle_incons_o,
    input logic cycle_long_o
);
    assert_new_cycle_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        new_cycle_o |=> !new_cycle_o);
    assert_sec64_on_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sec64_o |-> new_cycle_o);
    assert_lost_on_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_lost_o |-> new_cycle_o);
    assert_incons_after_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_incons_o |-> $past(rx_start_i));
    assert_long_needs_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_long_o |-> $past(master_i));
    assert_long_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_long_o |=> !cycle_long_o);
endmodule

bind iso_cycle_monitor iso_cycle_monitor_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rx_start_i(rx_start_i), .master_i(master_i),
    .new_cycle_o(new_cycle_o), .sec64_o(sec64_o), .cycle_lost_o(cycle_lost_o),
    .cycle_incons_o(cycle_incons_o), .cycle_long_o(cycle_long_o)
);

// File: tb/iso_cycle_monitor_tb_top.sv
`timescale 1ns/1ps
module iso_cycle_monitor_tb_top;
    localparam int OFF_LEN = 8;
    localparam int CPS     = 4;
    localparam int LIMIT   = 5;
    localparam int CNT_W   = 13;
    localparam int SEC_W   = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en_i = 1'b0, rx_start_i = 1'b0, tx_start_i = 1'b0;
    logic master_i = 1'b0, iso_done_i = 1'b0;
    logic [SEC_W-1:0] rx_sec_i = '0;
    logic [CNT_W-1:0] rx_cnt_i = '0;
    logic new_cycle_o, sec64_o, cycle_lost_o, cycle_incons_o, cycle_long_o;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    int sec64_seen = 0;

    always #2.5 clk = ~clk;

    iso_cycle_monitor #(
        .OFF_LEN(OFF_LEN), .CYC_PER_SEC(CPS), .LONG_LIMIT(LIMIT),
        .OFF_W(12), .CNT_W(CNT_W), .SEC_W(SEC_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
        .rx_start_i(rx_start_i), .rx_sec_i(rx_sec_i), .rx_cnt_i(rx_cnt_i),
        .tx_start_i(tx_start_i), .master_i(master_i), .iso_done_i(iso_done_i),
        .new_cycle_o(new_cycle_o), .sec64_o(sec64_o), .cycle_lost_o(cycle_lost_o),
        .cycle_incons_o(cycle_incons_o), .cycle_long_o(cycle_long_o)
    );

    // expected-value model built from the requirements
    int m_off, m_cnt, m_sec, m_st, m_el;
    bit e_new, e_sec, e_inc, e_lost, e_long;
    string t_inc = "R3", t_lost = "R5", t_long = "R7";

    function automatic bit is_wrap(int off, bit tick);
        return tick && (off == OFF_LEN - 1);
    endfunction

    function automatic bit is_roll(int off, int cnt, int sec, bit tick);
        return is_wrap(off, tick) && (cnt == CPS - 1) && ((sec % 64) == 63);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_off = 0; m_cnt = 0; m_sec = 0; m_st = 0; m_el = 0;
            e_new = 0; e_sec = 0; e_inc = 0; e_lost = 0; e_long = 0;
        end else begin
            bit w, s;
            w = is_wrap(m_off, tick_en_i);
            s = rx_start_i || tx_start_i;
            e_new  = w;
            e_sec  = is_roll(m_off, m_cnt, m_sec, tick_en_i);
            e_inc  = rx_start_i && ((int'(rx_sec_i) != m_sec) || (int'(rx_cnt_i) != m_cnt));
            t_inc  = (rx_start_i && !e_inc) ? "R4" : "R3";
            t_lost = (w && s) ? "R6" : "R5";
            t_long = master_i ? "R7" : "R8";
            e_lost = 0;
            e_long = 0;
            if (w) begin
                e_lost = (m_st == 1);
                m_st = s ? 2 : 1;
                m_el = 0;
            end else if (m_st == 1 && s) begin
                m_st = 2; m_el = 0;
            end else if (m_st == 2) begin
                if (iso_done_i) m_st = 3;
                else if (tick_en_i) begin
                    if (m_el == LIMIT - 1) begin
                        if (master_i) begin e_long = 1; m_st = 3; end
                    end else m_el++;
                end
            end
            if (tick_en_i) begin
                if (w) begin
                    m_off = 0;
                    if (m_cnt == CPS - 1) begin m_cnt = 0; m_sec = (m_sec + 1) % 128; end
                    else m_cnt++;
                end else m_off++;
            end
        end
    end

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic check_all();
        chk("R1", "new_cycle", new_cycle_o, e_new);
        chk("R2", "sec64", sec64_o, e_sec);
        chk(t_inc, "incons", cycle_incons_o, e_inc);
        chk(t_lost, "lost", cycle_lost_o, e_lost);
        chk(t_long, "long", cycle_long_o, e_long);
        if (sec64_o) sec64_seen++;
    endtask

    task automatic drive(int phase);
        bit match;
        tick_en_i  = (phase == 4) ? ($urandom_range(9) < 7) : 1'b1;
        tx_start_i = 0; rx_start_i = 0; iso_done_i = 0;
        rx_sec_i = SEC_W'(m_sec); rx_cnt_i = CNT_W'(m_cnt);
        unique case (phase)
            1: master_i = 1'b0;
            2: begin
                master_i   = 1'b1;
                tx_start_i = ($urandom_range(99) < 15);
                iso_done_i = ($urandom_range(99) < 6);
            end
            3: begin
                master_i   = 1'b1;
                rx_start_i = ($urandom_range(99) < 12);
                iso_done_i = ($urandom_range(99) < 4);
            end
            default: begin
                if ($urandom_range(99) < 3) master_i = ~master_i;
                tx_start_i = ($urandom_range(99) < 6);
                rx_start_i = ($urandom_range(99) < 8);
                iso_done_i = ($urandom_range(99) < 5);
            end
        endcase
        match = ($urandom_range(99) < 70);
        if (rx_start_i && !match) begin
            if ($urandom_range(1) == 0) rx_sec_i = rx_sec_i ^ SEC_W'(1 << $urandom_range(SEC_W - 1));
            else rx_cnt_i = rx_cnt_i ^ CNT_W'(1 << $urandom_range(CNT_W - 1));
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        // R9: all outputs low while reset is held
        chk("R9", "new_cycle", new_cycle_o, 1'b0);
        chk("R9", "sec64", sec64_o, 1'b0);
        chk("R9", "lost", cycle_lost_o, 1'b0);
        chk("R9", "incons", cycle_incons_o, 1'b0);
        chk("R9", "long", cycle_long_o, 1'b0);
        rst_n = 1'b1;
        // directed R6: start on the very tick of a wrap while awaiting a start
        drive(1);
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            check_all();
            drive(1);
            if (i == 30 && m_off == OFF_LEN - 1) tx_start_i = 1'b1;
        end
        for (int ph = 1; ph <= 4; ph++) begin
            int n;
            n = (ph == 3) ? 2600 : ((ph == 4) ? 3000 : 300);
            for (int i = 0; i < n; i++) begin
                @(negedge clk);
                check_all();
                drive(ph);
            end
        end
        @(negedge clk);
        check_all();
        // R2: the long run must have crossed seconds bit 6 at least once
        chk("R2", "sec64 seen", sec64_seen > 0, 1'b1);
        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            report();
        end
    end
endmodule